// File: doc/BRIEF.md
# Transmit Queue and FIFO Control

This block holds characters that the CPU writes for a serial transmitter until the transmitter takes them. It has two storage modes. In holding mode it behaves as a single holding register. In FIFO mode the same storage becomes a first-in first-out queue of `DEPTH` entries. It also tracks whether the transmitter's shift register is occupied, using a take/done handshake. From that it produces the two transmit status bits: holding-empty and transmitter-empty.

The block also decodes the write-only FIFO control byte. That byte selects the mode, sets the receive trigger code, and issues clear commands. Clears aimed at the receive side leave as a one-cycle strobe, `rx_clr`. The serial bit generator and interrupt identification sit outside this block.

Top module: `txq_ctl`

## Requirements
- R1: After synchronous reset, `thre`=1, `temt`=1, `fifo_en`=0, `rx_trig`=0, `rx_clr`=0 and `hold_valid`=0.
- R2: With `fifo_en`=0 the storage holds at most one character. A write clears `thre` on the next cycle. A write while a character is held is dropped, and `hold_data` keeps the first character.
- R3: A `shift_take` pulse moves the head character into the shift register only when `hold_valid`=1 and the shift register is idle. When no character remains, `thre` returns to 1.
- R4: `temt` is 1 only when the storage is empty and the shift register is idle. A `shift_done` pulse marks the shift register idle again.
- R5: With `fifo_en`=1 the queue accepts up to `DEPTH` characters and delivers them in write order. A write to a full queue is dropped.
- R6: Control bit 0 sets `fifo_en`. Any write that changes `fifo_en` empties the transmit storage and pulses `rx_clr` for one cycle.
- R7: Control bits 1, 2, 6 and 7 act only if `fifo_en` was already 1 before the write. Bits 7:6 load `rx_trig`, whose codes 0, 1, 2 and 3 mean 1, 4, 8 and 14 bytes.
- R8: When accepted, control bit 1 pulses `rx_clr` for one cycle and leaves the transmit queue untouched. When accepted, control bit 2 empties the transmit queue but leaves the shift register state alone. Neither bit is retained.
- R9: Control bits 3, 4 and 5 have no effect on any output.
- R10: If a transmit clear and a character write arrive in the same cycle, the clear wins and the character is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_wr | input | 1 | CPU write strobe for a transmit character |
| thr_wdata | input | DW | Character written by the CPU |
| fcr_wr | input | 1 | CPU write strobe for the FIFO control byte |
| fcr_wdata | input | 8 | FIFO control byte |
| shift_take | input | 1 | Transmitter request to load the head character into its shift register |
| shift_done | input | 1 | Transmitter has finished shifting out its character |
| hold_valid | output | 1 | A character is waiting at the head of the storage |
| hold_data | output | DW | Head character |
| thre | output | 1 | Holding register or queue empty |
| temt | output | 1 | Storage and shift register both empty |
| fifo_en | output | 1 | FIFO mode active |
| rx_trig | output | 2 | Receive trigger code |
| rx_clr | output | 1 | One-cycle clear strobe for the receive FIFO |

## Verification
Every result is due one clock edge after its stimulus. This covers `thre`, `temt`, `hold_valid`, `hold_data`, `fifo_en`, `rx_trig` and the one-cycle `rx_clr` strobe. The strobe drops again after the following edge. The bench drives each stimulus on a falling edge for exactly one cycle and samples on the next falling edge. It therefore reads values that settled after the single rising edge between them. Strobe checks are then repeated one cycle later to confirm that the pulse has ended.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // Bit positions inside the FIFO control byte
  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_RXCLR = 1;
  localparam int unsigned CB_TXCLR = 2;
  localparam int unsigned CB_TRLO  = 6;
  localparam int unsigned CB_TRHI  = 7;

  typedef struct packed {
    logic       mode_chg;
    logic       rx_kill;
    logic       tx_kill;
  } fcr_act_t;
endpackage

// File: rtl/txq_fcr_dec.sv
module txq_fcr_dec
  import txq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fcr_wr,
  input  logic [7:0] fcr_wdata,
  output logic       fifo_en,
  output logic [1:0] rx_trig,
  output logic       rx_clr,
  output logic       tx_flush
);
  fcr_act_t act;

  always_comb begin
    act.mode_chg = fcr_wr && (fcr_wdata[CB_EN] != fifo_en);
    act.rx_kill  = act.mode_chg || (fcr_wr && fifo_en && fcr_wdata[CB_RXCLR]);
    act.tx_kill  = act.mode_chg || (fcr_wr && fifo_en && fcr_wdata[CB_TXCLR]);
  end

  assign tx_flush = act.tx_kill;

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en <= 1'b0;
      rx_trig <= 2'd0;
      rx_clr  <= 1'b0;
    end else begin
      rx_clr <= act.rx_kill;
      if (fcr_wr) begin
        fifo_en <= fcr_wdata[CB_EN];
        if (fifo_en) rx_trig <= fcr_wdata[CB_TRHI:CB_TRLO];
      end
    end
  end
endmodule

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_mode,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [LW-1:0] level,
  output logic          empty_nxt
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, push_ok, pop_ok;
  logic [LW-1:0] level_nxt;

  assign full    = fifo_mode ? (level == LW'(DEPTH)) : (level != '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && (level != '0) && !flush;

  always_comb begin
    level_nxt = level;
    if (flush) level_nxt = '0;
    else begin
      if (push_ok) level_nxt = level_nxt + LW'(1);
      if (pop_ok)  level_nxt = level_nxt - LW'(1);
    end
  end
  assign empty_nxt = (level_nxt == '0);

  // Storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      level <= level_nxt;
    end
  end
endmodule

// File: rtl/txq_shift_trk.sv
module txq_shift_trk (
  input  logic clk,
  input  logic rst,
  input  logic take_ok,
  input  logic shift_done,
  output logic busy,
  output logic busy_nxt
);
  always_comb begin
    busy_nxt = busy;
    if (take_ok)         busy_nxt = 1'b1;
    else if (shift_done) busy_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) busy <= 1'b0;
    else     busy <= busy_nxt;
  end
endmodule

// File: rtl/txq_ctl.sv
module txq_ctl #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          thr_wr,
  input  logic [DW-1:0] thr_wdata,
  input  logic          fcr_wr,
  input  logic [7:0]    fcr_wdata,
  input  logic          shift_take,
  input  logic          shift_done,
  output logic          hold_valid,
  output logic [DW-1:0] hold_data,
  output logic          thre,
  output logic          temt,
  output logic          fifo_en,
  output logic [1:0]    rx_trig,
  output logic          rx_clr
);
  logic          tx_flush;
  logic [LW-1:0] tx_level;
  logic          empty_nxt;
  logic          sh_busy, busy_nxt;
  logic          take_ok;

  txq_fcr_dec u_dec (
    .clk(clk), .rst(rst), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
    .fifo_en(fifo_en), .rx_trig(rx_trig), .rx_clr(rx_clr), .tx_flush(tx_flush)
  );

  assign take_ok = shift_take && !sh_busy && (tx_level != '0) && !tx_flush;

  txq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .fifo_mode(fifo_en), .flush(tx_flush),
    .push(thr_wr), .push_data(thr_wdata), .pop(take_ok),
    .head_data(hold_data), .level(tx_level), .empty_nxt(empty_nxt)
  );

  txq_shift_trk u_trk (
    .clk(clk), .rst(rst), .take_ok(take_ok), .shift_done(shift_done),
    .busy(sh_busy), .busy_nxt(busy_nxt)
  );

  assign hold_valid = (tx_level != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      thre <= 1'b1;
      temt <= 1'b1;
    end else begin
      thre <= empty_nxt;
      temt <= empty_nxt && !busy_nxt;
    end
  end
endmodule

// File: rtl/txq_ctl_chk.sv
module txq_ctl_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          fcr_wr,
  input logic          shift_take,
  input logic          fifo_en,
  input logic [1:0]    rx_trig,
  input logic          rx_clr,
  input logic          thre,
  input logic          temt,
  input logic          hold_valid,
  input logic          sh_busy,
  input logic [LW-1:0] tx_level
);
  // R4
  temt_needs_thre_chk: assert property (@(posedge clk) disable iff (rst) temt |-> thre);
  // R8
  rx_clr_src_chk: assert property (@(posedge clk) disable iff (rst) rx_clr |-> $past(fcr_wr));
  // R7
  trig_hold_chk: assert property (@(posedge clk) disable iff (rst) !fcr_wr |=> $stable(rx_trig));
  // R6
  mode_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en != $past(fifo_en)) |-> (rx_clr && tx_level == '0));
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) tx_level <= LW'(DEPTH));
  // R2
  hold_cap_chk: assert property (@(posedge clk) disable iff (rst) !fifo_en |-> tx_level <= LW'(1));
  // R3
  take_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sh_busy) |-> $past(hold_valid && shift_take));
endmodule

bind txq_ctl txq_ctl_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .fcr_wr(fcr_wr), .shift_take(shift_take),
  .fifo_en(fifo_en), .rx_trig(rx_trig), .rx_clr(rx_clr), .thre(thre),
  .temt(temt), .hold_valid(hold_valid), .sh_busy(sh_busy), .tx_level(tx_level)
);

// File: tb/txq_ctl_test.sv
module txq_ctl_test;
  localparam int DW = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic thr_wr = 1'b0, fcr_wr = 1'b0, shift_take = 1'b0, shift_done = 1'b0;
  logic [DW-1:0] thr_wdata = '0;
  logic [7:0] fcr_wdata = '0;
  logic hold_valid, thre, temt, fifo_en, rx_clr;
  logic [DW-1:0] hold_data;
  logic [1:0] rx_trig;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  txq_ctl #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
    .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata), .shift_take(shift_take),
    .shift_done(shift_done), .hold_valid(hold_valid), .hold_data(hold_data),
    .thre(thre), .temt(temt), .fifo_en(fifo_en), .rx_trig(rx_trig), .rx_clr(rx_clr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic wr_thr(input logic [7:0] d);
    @(negedge clk); thr_wr = 1'b1; thr_wdata = d;
    @(negedge clk); thr_wr = 1'b0;
  endtask

  task automatic wr_fcr(input logic [7:0] d);
    @(negedge clk); fcr_wr = 1'b1; fcr_wdata = d;
    @(negedge clk); fcr_wr = 1'b0;
  endtask

  task automatic take();
    @(negedge clk); shift_take = 1'b1;
    @(negedge clk); shift_take = 1'b0;
  endtask

  task automatic done();
    @(negedge clk); shift_done = 1'b1;
    @(negedge clk); shift_done = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R1 thre", thre, 1);
    chk_eq("R1 temt", temt, 1);
    chk_eq("R1 fifo_en", fifo_en, 0);
    chk_eq("R1 rx_trig", rx_trig, 0);
    chk_eq("R1 rx_clr", rx_clr, 0);
    chk_eq("R1 hold_valid", hold_valid, 0);
  endtask

  task automatic t_hold();
    wr_thr(8'hA5);
    chk_eq("R2 thre after write", thre, 0);
    chk_eq("R4 temt after write", temt, 0);
    chk_eq("R2 head", hold_data, 8'hA5);
    wr_thr(8'h3C);
    chk_eq("R2 second write dropped", hold_data, 8'hA5);
    take();
    chk_eq("R3 hold_valid after take", hold_valid, 0);
    chk_eq("R3 thre after take", thre, 1);
    chk_eq("R4 temt while shifting", temt, 0);
    take();
    chk_eq("R3 take on empty keeps temt", temt, 0);
    done();
    chk_eq("R4 temt after done", temt, 1);
  endtask

  task automatic t_gate();
    wr_fcr(8'hC6);
    chk_eq("R7 trig ignored when off", rx_trig, 0);
    chk_eq("R7 rx clear ignored when off", rx_clr, 0);
    chk_eq("R7 still disabled", fifo_en, 0);
  endtask

  task automatic t_enable();
    wr_thr(8'h11);
    wr_fcr(8'hC1);
    chk_eq("R6 fifo_en set", fifo_en, 1);
    chk_eq("R6 rx_clr on mode change", rx_clr, 1);
    chk_eq("R6 tx flushed", hold_valid, 0);
    chk_eq("R6 thre after flush", thre, 1);
    chk_eq("R7 trig not taken on enabling write", rx_trig, 0);
    @(negedge clk);
    chk_eq("R6 rx_clr one cycle", rx_clr, 0);
    wr_fcr(8'h81);
    chk_eq("R7 trig loaded", rx_trig, 2);
    chk_eq("R7 no rx_clr", rx_clr, 0);
  endtask

  task automatic t_fifo();
    for (int i = 0; i < DEPTH; i++) wr_thr(8'h50 + 8'(i));
    wr_thr(8'hEE);
    chk_eq("R5 thre while full", thre, 0);
    for (int i = 0; i < DEPTH; i++) begin
      chk_eq("R5 order", hold_data, 8'h50 + 8'(i));
      take();
      done();
    end
    chk_eq("R5 overflow dropped", hold_valid, 0);
    chk_eq("R3 thre after drain", thre, 1);
    chk_eq("R4 temt after drain", temt, 1);
  endtask

  task automatic t_clr();
    wr_thr(8'h61); wr_thr(8'h62); wr_thr(8'h63);
    take();
    wr_fcr(8'h85);
    chk_eq("R8 tx clear empties", hold_valid, 0);
    chk_eq("R8 thre after tx clear", thre, 1);
    chk_eq("R8 shift spared temt", temt, 0);
    chk_eq("R8 tx clear no rx_clr", rx_clr, 0);
    done();
    chk_eq("R8 temt after done", temt, 1);
    wr_thr(8'h70);
    wr_fcr(8'h83);
    chk_eq("R8 rx clear strobe", rx_clr, 1);
    chk_eq("R8 tx untouched", hold_data, 8'h70);
    chk_eq("R8 tx still valid", hold_valid, 1);
    @(negedge clk);
    chk_eq("R8 self clearing", rx_clr, 0);
  endtask

  task automatic t_reserved();
    wr_fcr(8'hB9);
    chk_eq("R9 trig kept", rx_trig, 2);
    chk_eq("R9 no strobe", rx_clr, 0);
    chk_eq("R9 data kept", hold_data, 8'h70);
    chk_eq("R9 mode kept", fifo_en, 1);
  endtask

  task automatic t_same();
    @(negedge clk);
    thr_wr = 1'b1; thr_wdata = 8'h99; fcr_wr = 1'b1; fcr_wdata = 8'h85;
    @(negedge clk);
    thr_wr = 1'b0; fcr_wr = 1'b0;
    chk_eq("R10 clear wins", hold_valid, 0);
    chk_eq("R10 thre", thre, 1);
  endtask

  task automatic t_disable();
    wr_thr(8'h42);
    wr_fcr(8'h00);
    chk_eq("R6 disabled", fifo_en, 0);
    chk_eq("R6 rx_clr on disable", rx_clr, 1);
    chk_eq("R6 flush on disable", hold_valid, 0);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_gate();
    t_enable();
    t_fifo();
    t_clr();
    t_reserved();
    t_same();
    t_disable();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule